// File: doc/BRIEF.md
# Channel-Addressed Circular Capture Writer

This block lives on a receiver card at the far end of a serial link from a remote slow-signal digitizer. The link delivers one byte at a time. The block groups every four bytes into a 16-bit control word and a 16-bit data word. Sample words are written straight into a dual-port capture memory, with no processor involved. The write address is built from the current block index and the channel tag carried in the control word. Each block holds one reading per channel, and the buffer holds enough blocks for one second at a 10 kHz block rate. When the last block is full, the buffer wraps and overwrites the oldest data.

The host reads the block pointer to see which block is being filled. An interrupt request tells the host that a programmable number of blocks has completed. The request stays high until the host acknowledges it, and a saturating counter records every interrupt that fell due while an earlier one was still pending. Control words that do not carry a sample update a small register file that the host can read. A frame-sync input realigns the byte grouping and sets a sticky flag when it cuts a word short.

Top module: `capture_writer`

## Requirements
- R1: Byte grouping: four consecutive accepted bytes (`rx_valid` high) form one word. The first two bytes are the control word, high byte first. The next two bytes are the data word, high byte first.
- R2: A sample word (control bit 15 = 1) causes exactly one memory write, with `mem_we` high for one cycle on the second rising edge after the edge that accepts the fourth byte. The write uses `mem_addr = block * CHANNELS + channel`, where `channel` is control bits [log2(CHANNELS)-1:0], and `mem_wdata` = the data word.
- R3: The block index advances by one only when channel CHANNELS-1 is written, and wraps from BLOCKS-1 to 0. A sample on any other channel leaves it unchanged.
- R4: `blk_ptr` always shows the block currently being filled, and always stays below BLOCKS.
- R5: `irq` is raised on every `irq_div`-th completed block, counted from reset. An `irq_div` of 0 behaves as 1.
- R6: `irq` stays high until a cycle with `irq_ack` high clears it. If a new interrupt falls due in that same cycle, `irq` stays high.
- R7: When an interrupt falls due while `irq` is high and `irq_ack` is low, `miss_count` increases by one. It saturates at its maximum value.
- R8: A register word (control bit 15 = 0) stores the data word at register index control bits [log2(REGS)-1:0], readable on `reg_rd_data` at `reg_rd_addr`. It produces no memory write and does not move `blk_ptr`.
- R9: A byte accepted with `frame_sync` high is taken as byte 1 of a new word, and any partial word is discarded.
- R10: `align_err` sets when `frame_sync` arrives while 1 to 3 bytes of a word are held, and stays set until reset. A sync at a word boundary does not set it.
- R11: After reset: `blk_ptr` = 0, `irq` = 0, `miss_count` = 0, `align_err` = 0, `mem_we` = 0, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| frame_sync | input | 1 | Word alignment marker |
| irq_div | input | DIV_W | Completed blocks per interrupt (0 acts as 1) |
| irq_ack | input | 1 | Host acknowledge, clears irq |
| reg_rd_addr | input | log2(REGS) | Register file read index |
| mem_we | output | 1 | Capture memory write strobe |
| mem_addr | output | log2(BLOCKS*CHANNELS) | Capture memory write address |
| mem_wdata | output | 16 | Capture memory write data |
| blk_ptr | output | log2(BLOCKS) | Block currently being filled |
| irq | output | 1 | Level interrupt request |
| miss_count | output | MISS_W | Saturating count of missed interrupts |
| align_err | output | 1 | Sticky byte-alignment error flag |
| reg_rd_data | output | 16 | Register file read data |

## Verification
The fourth byte of a word is captured on one rising edge, and the assembled word is presented internally after that edge. The memory write, the block pointer step, the interrupt and miss-counter update and the register-file update all appear after the next rising edge, two edges after the fourth byte. The alignment flag updates on the same edge that accepts the sync byte. The bench drives each byte on a falling edge. The word task then waits one extra falling edge after the last byte, so every check it makes falls one half-cycle after the second edge. The scoreboard monitor samples the write strobe on every falling edge and matches each write against the queued expectation in order.

// File: rtl/cw_pkg.sv
package cw_pkg;

  localparam int unsigned WORD_W   = 16;
  localparam int unsigned KIND_BIT = 15;

  typedef enum logic {
    WK_REG    = 1'b0,
    WK_SAMPLE = 1'b1
  } word_kind_e;

  // Linear slot index inside the circular capture buffer.
  function automatic int unsigned slot_index(int unsigned blk, int unsigned ch,
                                             int unsigned chans);
    return blk * chans + ch;
  endfunction

  // Block index that follows blk in a ring of the given length.
  function automatic int unsigned block_after(int unsigned blk, int unsigned blocks);
    return (blk + 1 >= blocks) ? 0 : blk + 1;
  endfunction

  // True when the block now completing reaches the divider count.
  function automatic bit divider_hit(int unsigned done_before, int unsigned div);
    int unsigned eff;
    eff = (div == 0) ? 1 : div;
    return (done_before + 1) >= eff;
  endfunction

endpackage

// File: rtl/cw_byte_assembler.sv
module cw_byte_assembler
  import cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              frame_sync,
  output logic              word_stb,
  output logic [WORD_W-1:0] word_ctrl,
  output logic [WORD_W-1:0] word_data,
  output logic              byte_pending,
  output logic              align_err
);

  logic [1:0]  phase;
  logic [23:0] held;

  assign byte_pending = (phase != 2'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= '0;
      held      <= '0;
      word_stb  <= 1'b0;
      word_ctrl <= '0;
      word_data <= '0;
      align_err <= 1'b0;
    end else begin
      word_stb <= 1'b0;
      if (frame_sync) begin
        if (phase != 2'd0) align_err <= 1'b1;
        if (rx_valid) begin
          held  <= {held[15:0], rx_byte};
          phase <= 2'd1;
        end else begin
          phase <= 2'd0;
        end
      end else if (rx_valid) begin
        if (phase == 2'd3) begin
          word_ctrl <= held[23:8];
          word_data <= {held[7:0], rx_byte};
          word_stb  <= 1'b1;
          phase     <= 2'd0;
        end else begin
          held  <= {held[15:0], rx_byte};
          phase <= phase + 2'd1;
        end
      end
    end
  end

endmodule

// File: rtl/cw_slot_writer.sv
module cw_slot_writer
  import cw_pkg::*;
#(
  parameter int unsigned CHANNELS = 64,
  parameter int unsigned BLOCKS   = 10000,
  parameter int unsigned REGS     = 16,
  localparam int unsigned CH_W    = $clog2(CHANNELS),
  localparam int unsigned BLK_W   = $clog2(BLOCKS),
  localparam int unsigned ADDR_W  = $clog2(BLOCKS * CHANNELS),
  localparam int unsigned REG_AW  = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic [WORD_W-1:0] word_ctrl,
  input  logic [WORD_W-1:0] word_data,
  input  logic [REG_AW-1:0] reg_rd_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [BLK_W-1:0]  blk_ptr,
  output logic              block_done,
  output logic [WORD_W-1:0] reg_rd_data
);

  logic              is_sample;
  logic              is_reg;
  logic [CH_W-1:0]   chan;
  logic [REG_AW-1:0] reg_idx;
  logic [WORD_W-1:0] regs [REGS];
  logic              unused_ctrl;

  assign is_sample   = word_stb && (word_kind_e'(word_ctrl[KIND_BIT]) == WK_SAMPLE);
  assign is_reg      = word_stb && (word_kind_e'(word_ctrl[KIND_BIT]) == WK_REG);
  assign chan        = word_ctrl[CH_W-1:0];
  assign reg_idx     = word_ctrl[REG_AW-1:0];
  assign block_done  = is_sample && (chan == CH_W'(CHANNELS - 1));
  assign unused_ctrl = ^word_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      blk_ptr   <= '0;
    end else begin
      mem_we <= is_sample;
      if (is_sample) begin
        mem_addr  <= ADDR_W'(slot_index(32'(blk_ptr), 32'(chan), CHANNELS));
        mem_wdata <= word_data;
      end
      if (block_done)
        blk_ptr <= BLK_W'(block_after(32'(blk_ptr), BLOCKS));
    end
  end

  for (genvar g = 0; g < REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (is_reg && (reg_idx == REG_AW'(g)))
        regs[g] <= word_data;
    end
  end

  assign reg_rd_data = regs[reg_rd_addr];

endmodule

// File: rtl/cw_irq_pacer.sv
module cw_irq_pacer
  import cw_pkg::*;
#(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned MISS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              block_done,
  input  logic [DIV_W-1:0]  irq_div,
  input  logic              irq_ack,
  output logic              irq,
  output logic              irq_due,
  output logic [MISS_W-1:0] miss_count
);

  logic [DIV_W-1:0] done_cnt;

  assign irq_due = block_done && divider_hit(32'(done_cnt), 32'(irq_div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_cnt   <= '0;
      irq        <= 1'b0;
      miss_count <= '0;
    end else begin
      if (irq_due)
        done_cnt <= '0;
      else if (block_done)
        done_cnt <= done_cnt + 1'b1;

      if (irq_due)
        irq <= 1'b1;
      else if (irq_ack)
        irq <= 1'b0;

      if (irq_due && irq && !irq_ack && (miss_count != '1))
        miss_count <= miss_count + 1'b1;
    end
  end

endmodule

// File: rtl/capture_writer.sv
module capture_writer
  import cw_pkg::*;
#(
  parameter int unsigned CHANNELS = 64,
  parameter int unsigned BLOCKS   = 10000,
  parameter int unsigned REGS     = 16,
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned MISS_W   = 8,
  localparam int unsigned BLK_W   = $clog2(BLOCKS),
  localparam int unsigned ADDR_W  = $clog2(BLOCKS * CHANNELS),
  localparam int unsigned REG_AW  = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              frame_sync,
  input  logic [DIV_W-1:0]  irq_div,
  input  logic              irq_ack,
  input  logic [REG_AW-1:0] reg_rd_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic [BLK_W-1:0]  blk_ptr,
  output logic              irq,
  output logic [MISS_W-1:0] miss_count,
  output logic              align_err,
  output logic [15:0]       reg_rd_data
);

  // Internal events brought out by name for the checker.
  logic              word_stb;
  logic [WORD_W-1:0] word_ctrl;
  logic [WORD_W-1:0] word_data;
  logic              byte_pending;
  logic              block_done;
  logic              irq_due;

  cw_byte_assembler u_asm (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .rx_byte      (rx_byte),
    .frame_sync   (frame_sync),
    .word_stb     (word_stb),
    .word_ctrl    (word_ctrl),
    .word_data    (word_data),
    .byte_pending (byte_pending),
    .align_err    (align_err)
  );

  cw_slot_writer #(
    .CHANNELS (CHANNELS),
    .BLOCKS   (BLOCKS),
    .REGS     (REGS)
  ) u_wr (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_stb    (word_stb),
    .word_ctrl   (word_ctrl),
    .word_data   (word_data),
    .reg_rd_addr (reg_rd_addr),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .blk_ptr     (blk_ptr),
    .block_done  (block_done),
    .reg_rd_data (reg_rd_data)
  );

  cw_irq_pacer #(
    .DIV_W  (DIV_W),
    .MISS_W (MISS_W)
  ) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .block_done (block_done),
    .irq_div    (irq_div),
    .irq_ack    (irq_ack),
    .irq        (irq),
    .irq_due    (irq_due),
    .miss_count (miss_count)
  );

endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
  parameter int unsigned BLOCKS = 10000,
  parameter int unsigned BLK_W  = 14,
  parameter int unsigned MISS_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_sync,
  input logic              irq_ack,
  input logic              word_stb,
  input logic              word_is_sample,
  input logic              byte_pending,
  input logic              block_done,
  input logic              irq_due,
  input logic              mem_we,
  input logic              irq,
  input logic              align_err,
  input logic [BLK_W-1:0]  blk_ptr,
  input logic [MISS_W-1:0] miss_count
);

  assert_write_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && word_is_sample) |=> mem_we);

  assert_no_stray_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_stb && !word_is_sample) |=> !mem_we);

  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(blk_ptr) < BLOCKS);

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    block_done |=> (32'(blk_ptr) ==
      ((32'($past(blk_ptr)) + 1 >= BLOCKS) ? 0 : 32'($past(blk_ptr)) + 1)));

  assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !block_done |=> $stable(blk_ptr));

  assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_due |=> irq);

  assert_irq_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  assert_miss_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_due && irq && !irq_ack && (miss_count != '1)) |=>
      (miss_count == $past(miss_count) + 1'b1));

  assert_align_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && byte_pending) |=> align_err);

  assert_align_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);

endmodule

bind capture_writer cw_checker #(
  .BLOCKS (BLOCKS),
  .BLK_W  (BLK_W),
  .MISS_W (MISS_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .frame_sync     (frame_sync),
  .irq_ack        (irq_ack),
  .word_stb       (word_stb),
  .word_is_sample (word_ctrl[15]),
  .byte_pending   (byte_pending),
  .block_done     (block_done),
  .irq_due        (irq_due),
  .mem_we         (mem_we),
  .irq            (irq),
  .align_err      (align_err),
  .blk_ptr        (blk_ptr),
  .miss_count     (miss_count)
);

// File: tb/capture_writer_test.sv
module capture_writer_test;

  localparam int CLK_PERIOD = 10;
  localparam int CH     = 4;
  localparam int NBLK   = 5;
  localparam int NREG   = 16;
  localparam int DIV_W  = 8;
  localparam int MISS_W = 8;
  localparam int BLK_W  = $clog2(NBLK);
  localparam int ADDR_W = $clog2(NBLK * CH);
  localparam int REG_AW = $clog2(NREG);
  localparam int WATCHDOG = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              rx_valid = 1'b0;
  logic [7:0]        rx_byte = '0;
  logic              frame_sync = 1'b0;
  logic [DIV_W-1:0]  irq_div = 8'd2;
  logic              irq_ack = 1'b0;
  logic [REG_AW-1:0] reg_rd_addr = '0;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [15:0]       mem_wdata;
  logic [BLK_W-1:0]  blk_ptr;
  logic              irq;
  logic [MISS_W-1:0] miss_count;
  logic              align_err;
  logic [15:0]       reg_rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  int exp_blk = 0;
  bit done = 1'b0;
  logic [ADDR_W+15:0] exp_q[$];

  capture_writer #(
    .CHANNELS (CH), .BLOCKS (NBLK), .REGS (NREG), .DIV_W (DIV_W), .MISS_W (MISS_W)
  ) uut (
    .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_byte (rx_byte),
    .frame_sync (frame_sync), .irq_div (irq_div), .irq_ack (irq_ack),
    .reg_rd_addr (reg_rd_addr), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .blk_ptr (blk_ptr), .irq (irq),
    .miss_count (miss_count), .align_err (align_err), .reg_rd_data (reg_rd_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drives four bytes, then waits until the word's results are visible.
  task automatic send_word(input logic [15:0] c, input logic [15:0] d, input bit sync);
    logic [7:0] b [4];
    b[0] = c[15:8]; b[1] = c[7:0]; b[2] = d[15:8]; b[3] = d[7:0];
    for (int i = 0; i < 4; i++) begin
      rx_byte    = b[i];
      rx_valid   = 1'b1;
      frame_sync = sync && (i == 0);
      @(negedge clk);
    end
    rx_valid   = 1'b0;
    frame_sync = 1'b0;
    @(negedge clk);
  endtask

  // Scoreboard driver: queue the expected write, then send the sample word.
  task automatic send_sample(input int ch, input logic [15:0] d, input bit sync);
    exp_q.push_back({ADDR_W'(exp_blk * CH + ch), d});
    if (ch == CH - 1) exp_blk = (exp_blk + 1) % NBLK;
    send_word(16'h8000 | 16'(ch), d, sync);
  endtask

  task automatic send_block(input logic [15:0] seed);
    for (int c = 0; c < CH; c++) send_sample(c, seed + 16'(c), 1'b0);
  endtask

  // Scoreboard monitor (R1, R2).
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2/R8: actual write %0h:%0h expected none", mem_addr, mem_wdata);
      end else begin
        logic [ADDR_W+15:0] e;
        e = exp_q.pop_front();
        check("R1/R2 write addr+data", 32'({mem_addr, mem_wdata}), 32'(e));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    check("R11 blk_ptr", 32'(blk_ptr), 0);
    check("R11 irq", 32'(irq), 0);
    check("R11 miss_count", 32'(miss_count), 0);
    check("R11 align_err", 32'(align_err), 0);
    check("R11 mem_we", 32'(mem_we), 0);
    reg_rd_addr = 4'd5;
    #1 check("R11 reg reset", 32'(reg_rd_data), 0);

    // R9/R10: sync at a word boundary, no error
    send_sample(0, 16'h1234, 1'b1);
    check("R10 no error at boundary", 32'(align_err), 0);
    send_sample(1, 16'hA5C3, 1'b0);
    send_sample(2, 16'h5A3C, 1'b0);
    check("R3 no advance mid-block", 32'(blk_ptr), 0);
    send_sample(3, 16'h0F0F, 1'b0);
    check("R3 advance on last channel", 32'(blk_ptr), 1);
    check("R5 no irq after 1 of 2 blocks", 32'(irq), 0);

    // R8 register word
    send_word(16'h0005, 16'hBEEF, 1'b0);
    check("R8 register stored", 32'(reg_rd_data), 32'h0000BEEF);
    check("R8 pointer unchanged", 32'(blk_ptr), 1);

    // R5/R6/R7 interrupt pacing
    send_block(16'h1100);
    check("R4 blk_ptr", 32'(blk_ptr), 2);
    check("R5 irq after 2 blocks", 32'(irq), 1);
    send_block(16'h2200);
    check("R6 irq held", 32'(irq), 1);
    check("R7 no miss yet", 32'(miss_count), 0);
    send_block(16'h3300);
    check("R7 miss counted", 32'(miss_count), 1);
    check("R4 blk_ptr", 32'(blk_ptr), 4);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R6 ack clears irq", 32'(irq), 0);

    // R3 wrap
    send_block(16'h4400);
    check("R3 wrap to 0", 32'(blk_ptr), 0);
    check("R5 no irq on odd block", 32'(irq), 0);

    // R9/R10 sync mid-word
    rx_byte = 8'hDE; rx_valid = 1'b1; @(negedge clk);
    rx_byte = 8'hAD; @(negedge clk);
    rx_valid = 1'b0;
    check("R10 no error before sync", 32'(align_err), 0);
    send_sample(0, 16'hC0DE, 1'b1);
    check("R10 error on mid-word sync", 32'(align_err), 1);

    // R5 divider 0 acts as 1
    irq_div = '0;
    send_sample(1, 16'h0001, 1'b0);
    send_sample(2, 16'h0002, 1'b0);
    check("R5 no irq mid-block", 32'(irq), 0);
    send_sample(3, 16'h0003, 1'b0);
    check("R5 irq with divider 0", 32'(irq), 1);
    check("R10 error sticky", 32'(align_err), 1);
    check("R4 blk_ptr", 32'(blk_ptr), 1);

    repeat (2) @(negedge clk);
    check("R2 all writes seen", 32'(exp_q.size()), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule